// File: doc/BRIEF.md
# Backplane Slave Address Recognizer

This block monitors a 16-bit parallel backplane address bus and signals when a small fixed slave window is being addressed. A hit needs three things together: the address falls in the four-word window 0xFF84 to 0xFF87, the active-low half-cycle qualifier is high, and both bus phase bits are low. When all three hold, the block raises a raw hit. It then reports the hit as an active-low recognition strobe to the panel's state controller.

All bus inputs first pass through a two-flop synchronizer. Address lines can still be settling when they reach the comparator. To stop that from causing a false hit, the rising edge of the raw hit is held back for a programmable number of clock cycles. The raw hit has to stay true for the whole count. If it drops at any point, the count starts again from zero. The falling edge of the raw hit is not delayed, so recognition withdraws as soon as the synchronized inputs stop matching.

All pins are plain control and status signals. No data flows through the block, so it has no valid/ready interface and no back-pressure rules.

Top module: `bus_slave_recog`

## Requirements
- R1: With the qualifier high and both phase bits 0, any address whose bits [15:2] equal 0x3FE1 (0xFF84, 0xFF85, 0xFF86, 0xFF87) is recognized; the two low address bits have no effect.
- R2: While `half_cyc_n` is 0, `recog_n` stays 1 for every address.
- R3: While `bus_phase` is not 2'b00, `recog_n` stays 1 for every address.
- R4: Any address outside 0xFF84 to 0xFF87 keeps `recog_n` at 1, whatever the qualifier and phase values.
- R5: When a matching input set is applied and then held, `recog_n` goes to 0 right after the (2 + SETTLE_CYC)-th rising clock edge, counting from when the inputs are applied. Before that edge it stays 1.
- R6: When a held match is replaced by a non-matching input set, `recog_n` returns to 1 right after the second rising edge. No settle delay applies to this edge.
- R7: If the synchronized raw hit drops for even one cycle, the settle count restarts. A new match then needs the full 2 + SETTLE_CYC edges.
- R8: A synchronous active-high `rst` clears the synchronizer and the settle counter, and drives `recog_n` to 1 on the first edge where it is sampled high.
- R9: Inputs reach the comparator only through two register stages. A withdrawn match therefore still shows `recog_n` = 0 after the first edge that follows the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Backplane address lines |
| half_cyc_n | input | 1 | Active-low half-cycle qualifier; recognition is allowed only while it is 1 |
| bus_phase | input | 2 | Bus phase bits; both must be 0 for a hit |
| recog_n | output | 1 | Active-low address-recognized strobe |

## Verification
The checker rebuilds the two-stage input pipeline and checks on every cycle that `recog_n` stays high whenever the synchronized qualifier, phase or address rules out a hit. It also checks that a low output is always preceded by a raw hit in the previous cycle, and that the output is released on the cycle after reset. The exact settle latency, the restart of the count after a one-cycle drop, and the two-edge release timing can only be shown by the bench scenarios. These include a sweep of every address in the 0xFF00 page under all qualifier and phase combinations, plus a strided sweep of the full address space.

// File: rtl/recog_pkg.sv
package recog_pkg;
  localparam int PHASE_W = 2;

  // Idle phase code: both bits low.
  localparam logic [PHASE_W-1:0] PHASE_IDLE = '0;

  function automatic logic phase_ok(input logic [PHASE_W-1:0] ph);
    return ph == PHASE_IDLE;
  endfunction
endpackage

// File: rtl/recog_sync.sv
module recog_sync #(
  parameter int W      = 19,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/recog_cmp.sv
module recog_cmp
  import recog_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DC_BITS    = 2,
  parameter logic [ADDR_W-1:0] MATCH_BASE = 16'hFF84
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               qual_n,
  input  logic [PHASE_W-1:0] phase,
  output logic               raw_hit
);
  localparam int CMP_W = ADDR_W - DC_BITS;
  localparam logic [CMP_W-1:0] PATTERN = MATCH_BASE[ADDR_W-1:DC_BITS];

  logic addr_eq;
  assign addr_eq = addr[ADDR_W-1:DC_BITS] == PATTERN;
  assign raw_hit = addr_eq & qual_n & phase_ok(phase);
endmodule

// File: rtl/recog_rise_delay.sv
module recog_rise_delay #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic hit_in,
  output logic hit_out
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !hit_in) cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  // Rising edge waits for the count; falling edge follows hit_in at once.
  assign hit_out = hit_in & (cnt == LIMIT);
endmodule

// File: rtl/bus_slave_recog.sv
module bus_slave_recog
  import recog_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter int                DC_BITS     = 2,
  parameter logic [ADDR_W-1:0] MATCH_BASE  = 16'hFF84,
  parameter int                SETTLE_CYC  = 4,
  parameter int                SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               half_cyc_n,
  input  logic [PHASE_W-1:0] bus_phase,
  output logic               recog_n
);
  localparam int BUNDLE_W = ADDR_W + 1 + PHASE_W;

  logic [BUNDLE_W-1:0] bundle_raw, bundle_sync;
  logic [ADDR_W-1:0]   s_addr;
  logic                s_qual_n;
  logic [PHASE_W-1:0]  s_phase;
  logic                raw_hit, settled_hit;

  assign bundle_raw = {bus_addr, half_cyc_n, bus_phase};

  recog_sync #(.W(BUNDLE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(bundle_raw), .q(bundle_sync)
  );

  assign {s_addr, s_qual_n, s_phase} = bundle_sync;

  recog_cmp #(.ADDR_W(ADDR_W), .DC_BITS(DC_BITS), .MATCH_BASE(MATCH_BASE)) u_cmp (
    .addr(s_addr), .qual_n(s_qual_n), .phase(s_phase), .raw_hit(raw_hit)
  );

  recog_rise_delay #(.SETTLE_CYC(SETTLE_CYC)) u_dly (
    .clk(clk), .rst(rst), .hit_in(raw_hit), .hit_out(settled_hit)
  );

  assign recog_n = ~settled_hit;
endmodule

// File: rtl/bus_slave_recog_chk.sv
module bus_slave_recog_chk
  import recog_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DC_BITS    = 2,
  parameter logic [ADDR_W-1:0] MATCH_BASE = 16'hFF84
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               half_cyc_n,
  input logic [PHASE_W-1:0] bus_phase,
  input logic               recog_n
);
  // Independent two-stage view of the bus inputs.
  logic [ADDR_W-1:0]  a1, a2;
  logic               q1, q2;
  logic [PHASE_W-1:0] p1, p2;

  always_ff @(posedge clk) begin
    if (rst) begin
      a1 <= '0; a2 <= '0; q1 <= 1'b0; q2 <= 1'b0; p1 <= '0; p2 <= '0;
    end else begin
      a1 <= bus_addr;   a2 <= a1;
      q1 <= half_cyc_n; q2 <= q1;
      p1 <= bus_phase;  p2 <= p1;
    end
  end

  logic in_window, hit_c;
  assign in_window = (a2 >= MATCH_BASE) &&
                     (a2 <= (MATCH_BASE | ADDR_W'((1 << DC_BITS) - 1)));
  assign hit_c = in_window && q2 && (p2 == '0);

  a_r2_qual_blocks: assert property (@(posedge clk) disable iff (rst)
    !q2 |-> recog_n);

  a_r3_phase_blocks: assert property (@(posedge clk) disable iff (rst)
    (p2 != '0) |-> recog_n);

  a_r4_outside_window: assert property (@(posedge clk) disable iff (rst)
    !in_window |-> recog_n);

  a_r5_hit_held: assert property (@(posedge clk) disable iff (rst)
    !recog_n |-> (hit_c && $past(hit_c)));

  a_r8_reset_release: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> recog_n);
endmodule

bind bus_slave_recog bus_slave_recog_chk #(
  .ADDR_W(ADDR_W), .DC_BITS(DC_BITS), .MATCH_BASE(MATCH_BASE)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .half_cyc_n(half_cyc_n),
  .bus_phase(bus_phase), .recog_n(recog_n)
);

// File: tb/bus_slave_recog_tb.sv
module bus_slave_recog_tb;
  localparam int DLY = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = 16'h0000;
  logic        half_cyc_n = 1'b1;
  logic [1:0]  bus_phase = 2'b00;
  logic        recog_n;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  bus_slave_recog #(.SETTLE_CYC(DLY)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .half_cyc_n(half_cyc_n),
    .bus_phase(bus_phase), .recog_n(recog_n)
  );

  function automatic logic expect_hit(input logic [15:0] a, input logic q,
                                      input logic [1:0] p);
    return (a >= 16'hFF84) && (a <= 16'hFF87) && q && (p == 2'b00);
  endfunction

  task automatic chk(input string req, input logic exp_n);
    checks++;
    if (recog_n !== exp_n) begin
      fails++;
      $display("FAIL %s: recog_n=%b expected %b (addr=%h qual=%b phase=%b) t=%0t",
               req, recog_n, exp_n, bus_addr, half_cyc_n, bus_phase, $time);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic q, input logic [1:0] p);
    bus_addr = a; half_cyc_n = q; bus_phase = p;
  endtask

  // Called just after a negedge, from an idle state.
  task automatic run_vec(input logic [15:0] a, input logic q, input logic [1:0] p);
    logic e;
    string tag;
    e = expect_hit(a, q, p);
    if (e) tag = "R1";
    else if (!q) tag = "R2";
    else if (p != 2'b00) tag = "R3";
    else tag = "R4";
    drive(a, q, p);
    for (int k = 1; k <= DLY + 1; k++) begin
      @(negedge clk);
      chk("R5 no early hit", 1'b1);
    end
    @(negedge clk);
    chk(tag, ~e);
    drive(16'h0000, 1'b1, 2'b00);
    @(negedge clk);
    chk("R9 sync latency", ~e);
    @(negedge clk);
    chk("R6 immediate release", 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset state", 1'b1);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);

    // Every address in the 0xFF00 page under every qualifier/phase combination.
    for (int hi = 0; hi < 256; hi++) begin
      for (int c = 0; c < 8; c++) begin
        run_vec(16'hFF00 | 16'(hi), c[2], c[1:0]);
      end
    end

    // Strided sweep of the whole address space with a good qualifier.
    for (int a = 0; a < 65536; a += 251) begin
      run_vec(16'(a), 1'b1, 2'b00);
    end

    // R7: one-cycle drop restarts the settle count.
    drive(16'hFF86, 1'b1, 2'b00);
    repeat (3) @(negedge clk);
    drive(16'h1234, 1'b1, 2'b00);
    @(negedge clk);
    drive(16'hFF86, 1'b1, 2'b00);
    for (int k = 1; k <= DLY + 1; k++) begin
      @(negedge clk);
      chk("R7 restart", 1'b1);
    end
    @(negedge clk);
    chk("R7 restart", 1'b0);

    // R8: reset while recognized.
    rst = 1'b1;
    @(negedge clk);
    chk("R8 reset clears", 1'b1);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 1; k <= DLY + 1; k++) begin
      @(negedge clk);
      chk("R8 counter cleared", 1'b1);
    end
    @(negedge clk);
    chk("R8 re-recognize", 1'b0);
    drive(16'h0000, 1'b1, 2'b00);
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #3_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule